// File: doc/BRIEF.md
# Temperature Alarm Event Generator

This block watches a stream of temperature samples and turns them into a single alarm pin plus three status flags. Each time a new sample is strobed in, it is compared against a lower alarm limit, an upper alarm limit and a critical trip limit. All three comparisons are signed. Samples arrive a few times per second, so every sample is evaluated exactly once.

The alarm pin has four operating modes:
- **Comparator:** the pin follows the out-of-window condition, for thermostat-style control.
- **Interrupt:** the pin latches an excursion for a host processor. The host acknowledges it with a clear pulse.
- **Critical-only:** the pin reacts solely to the critical limit. This override takes precedence over the other two modes.
- **Disabled:** the pin is released. The flags keep tracking the samples.

The asserted level is selectable. The open-drain pin is represented as a level plus a pull-down enable.

Top module: `thermal_event_gen`

## Requirements
- R1: One cycle after a cycle with `sample_valid` high, the flags are updated from that cycle's `sample_temp`. All values are two's complement with a quarter-degree LSB, and the comparisons are signed and strict:
  - `flag_below` = temperature < `lim_low`
  - `flag_above` = temperature > `lim_high`
  - `flag_crit` = temperature > `lim_crit`
- R2: In a cycle without `sample_valid`, the flags keep their values, whatever `sample_temp` carries.
- R3: After reset, all flags are 0, `evt_level` is 1 and `evt_oe` is 0.
- R4: While enabled, the asserted pin level is 1 when `cfg_active_high` is 1 and 0 when it is 0. `evt_oe` is 1 exactly when `evt_level` is 0.
- R5: Comparator mode is selected by `cfg_irq_mode`=0 and `cfg_crit_only`=0. In this mode the pin is asserted, one cycle after the inputs, exactly when any flag is set.
- R6: Interrupt mode is selected by `cfg_irq_mode`=1 and `cfg_crit_only`=0.
  - A sample outside the window (below, above or critical), seen while the latch is armed, latches the event.
  - The latched event keeps the pin asserted, even when later samples are inside the window, until an `irq_clear` pulse.
  - In every other mode the latch is empty and armed.
- R7: Latching an event disarms the latch. Further out-of-window samples set nothing until a sample inside the window re-arms it.
- R8: In interrupt mode, the pin stays asserted while `flag_crit` is set, even after `irq_clear`. It is released on the first sample below or at the critical limit, provided nothing is latched.
- R9: With `cfg_crit_only`=1, the pin is asserted exactly when `flag_crit` is set, whatever `cfg_irq_mode` holds.
- R10: With `cfg_enable`=0, the pin is released (`evt_level`=1, `evt_oe`=0), while the flags and the latch keep updating.
- R11: When a new latching sample and `irq_clear` fall in the same cycle, the event is latched and the pin stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe marking a new sample |
| sample_temp | input | TW | Signed sample, quarter-degree LSB |
| lim_low | input | TW | Signed lower alarm limit |
| lim_high | input | TW | Signed upper alarm limit |
| lim_crit | input | TW | Signed critical limit |
| cfg_enable | input | 1 | 1 lets the pin assert |
| cfg_active_high | input | 1 | 1 = asserted level high, 0 = asserted level low |
| cfg_irq_mode | input | 1 | 1 = interrupt (latched), 0 = comparator |
| cfg_crit_only | input | 1 | 1 = pin reacts to the critical limit only |
| irq_clear | input | 1 | Host pulse that clears a latched event |
| evt_level | output | 1 | Pin level as seen with the pull-up |
| evt_oe | output | 1 | 1 = pin actively pulled low |
| flag_below | output | 1 | Last sample below the lower limit |
| flag_above | output | 1 | Last sample above the upper limit |
| flag_crit | output | 1 | Last sample above the critical limit |

## Verification
Two events can collide in the same cycle: a host clear and a new excursion that re-latches the interrupt.

The bench provokes this in a directed way. It first re-arms the latch with an in-window sample while an old event is still pending. It then presents an above-limit sample together with `irq_clear`. The pin must stay asserted.

A second overlap happens when a clear arrives while the critical flag is set. The pin must also remain asserted in that case.

Random cycles mix clears, samples near every limit and mode changes. This produces many more of both overlaps, and every cycle is judged against a bench model of the flags, the latch and the pin.

// File: rtl/tev_pkg.sv
package tev_pkg;

    typedef struct packed {
        logic below;
        logic above;
        logic crit;
    } trip_flags_t;

    typedef enum logic [1:0] {
        MODE_COMPARE  = 2'd0,
        MODE_LATCH    = 2'd1,
        MODE_CRIT_ONLY = 2'd2
    } out_mode_e;

    typedef struct packed {
        trip_flags_t flags;
        logic        irq;
        logic        armed;
        logic        level;
        logic        oe;
    } tev_state_t;

    function automatic out_mode_e decode_mode(input logic irq_mode, input logic crit_only);
        if (crit_only)
            return MODE_CRIT_ONLY;
        else if (irq_mode)
            return MODE_LATCH;
        else
            return MODE_COMPARE;
    endfunction

endpackage

// File: rtl/tev_trip_cmp.sv
module tev_trip_cmp
    import tev_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic signed [TW-1:0] sample,
    input  logic signed [TW-1:0] lim_lo,
    input  logic signed [TW-1:0] lim_hi,
    input  logic signed [TW-1:0] lim_cr,
    output trip_flags_t          hit
);
    localparam int NLIM = 3;

    logic signed [TW-1:0] lim [NLIM];
    logic [NLIM-1:0]      res;

    assign lim[0] = lim_lo;
    assign lim[1] = lim_hi;
    assign lim[2] = lim_cr;

    // slot 0 trips below its limit, the others trip above theirs
    for (genvar i = 0; i < NLIM; i++) begin : g_cmp
        if (i == 0) begin : g_lt
            assign res[i] = sample < lim[i];
        end else begin : g_gt
            assign res[i] = sample > lim[i];
        end
    end

    assign hit.below = res[0];
    assign hit.above = res[1];
    assign hit.crit  = res[2];

endmodule

// File: rtl/tev_irq_latch.sv
module tev_irq_latch
    import tev_pkg::*;
(
    input  out_mode_e mode,
    input  logic      sample_valid,
    input  logic      outside,
    input  logic      irq_clear,
    input  logic      irq_q,
    input  logic      armed_q,
    output logic      irq_d,
    output logic      armed_d
);
    logic set_evt;

    always_comb begin
        set_evt = 1'b0;
        irq_d   = 1'b0;
        armed_d = 1'b1;
        if (mode == MODE_LATCH) begin
            set_evt = sample_valid && outside && armed_q;
            // a new event outranks a clear in the same cycle
            irq_d   = set_evt || (irq_q && !irq_clear);
            if (sample_valid)
                armed_d = !outside;
            else
                armed_d = armed_q;
        end
    end

endmodule

// File: rtl/tev_pin_drive.sv
module tev_pin_drive
    import tev_pkg::*;
(
    input  out_mode_e   mode,
    input  logic        enable,
    input  logic        active_high,
    input  trip_flags_t flags,
    input  logic        irq,
    output logic        level,
    output logic        oe
);
    logic active;

    always_comb begin
        unique case (mode)
            MODE_CRIT_ONLY: active = flags.crit;
            MODE_LATCH:     active = irq || flags.crit;
            default:        active = flags.below || flags.above || flags.crit;
        endcase

        if (!enable)
            level = 1'b1;
        else
            level = active ? active_high : !active_high;

        oe = !level;
    end

endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
    import tev_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic [TW-1:0] sample_temp,
    input  logic [TW-1:0] lim_low,
    input  logic [TW-1:0] lim_high,
    input  logic [TW-1:0] lim_crit,
    input  logic          cfg_enable,
    input  logic          cfg_active_high,
    input  logic          cfg_irq_mode,
    input  logic          cfg_crit_only,
    input  logic          irq_clear,
    output logic          evt_level,
    output logic          evt_oe,
    output logic          flag_below,
    output logic          flag_above,
    output logic          flag_crit
);
    localparam tev_state_t RESET_STATE = '{
        flags: '{below: 1'b0, above: 1'b0, crit: 1'b0},
        irq:   1'b0,
        armed: 1'b1,
        level: 1'b1,
        oe:    1'b0
    };

    tev_state_t  state_q, state_d;
    trip_flags_t hit;
    trip_flags_t flags_nxt;
    out_mode_e   mode;
    logic        irq_nxt, armed_nxt;
    logic        level_nxt, oe_nxt;

    assign mode = decode_mode(cfg_irq_mode, cfg_crit_only);

    tev_trip_cmp #(.TW(TW)) u_cmp (
        .sample (sample_temp),
        .lim_lo (lim_low),
        .lim_hi (lim_high),
        .lim_cr (lim_crit),
        .hit    (hit)
    );

    assign flags_nxt = sample_valid ? hit : state_q.flags;

    tev_irq_latch u_latch (
        .mode         (mode),
        .sample_valid (sample_valid),
        .outside      (hit.below || hit.above || hit.crit),
        .irq_clear    (irq_clear),
        .irq_q        (state_q.irq),
        .armed_q      (state_q.armed),
        .irq_d        (irq_nxt),
        .armed_d      (armed_nxt)
    );

    tev_pin_drive u_pin (
        .mode        (mode),
        .enable      (cfg_enable),
        .active_high (cfg_active_high),
        .flags       (flags_nxt),
        .irq         (irq_nxt),
        .level       (level_nxt),
        .oe          (oe_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flags_nxt;
        state_d.irq   = irq_nxt;
        state_d.armed = armed_nxt;
        state_d.level = level_nxt;
        state_d.oe    = oe_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RESET_STATE;
        else
            state_q <= state_d;
    end

    assign evt_level  = state_q.level;
    assign evt_oe     = state_q.oe;
    assign flag_below = state_q.flags.below;
    assign flag_above = state_q.flags.above;
    assign flag_crit  = state_q.flags.crit;

endmodule

// File: rtl/tev_checker.sv
module tev_checker (
    input logic clk,
    input logic rst_n,
    input logic sample_valid,
    input logic irq_clear,
    input logic cfg_enable,
    input logic cfg_active_high,
    input logic cfg_irq_mode,
    input logic cfg_crit_only,
    input logic flag_below,
    input logic flag_above,
    input logic flag_crit,
    input logic evt_level,
    input logic evt_oe
);
    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable({flag_below, flag_above, flag_crit}));

    a_r10_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (evt_level && !evt_oe));

    a_r9_crit_only_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_crit_only && !cfg_active_high) |=> (evt_level == !flag_crit));

    a_r5_comparator_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_irq_mode && !cfg_crit_only && cfg_active_high)
        |=> (evt_level == (flag_below || flag_above || flag_crit)));

    a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_irq_mode && !cfg_crit_only && cfg_active_high &&
         irq_clear && !sample_valid && !flag_crit) |=> !evt_level);

    a_r4_oe_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        evt_oe == !evt_level);

endmodule

bind thermal_event_gen tev_checker u_tev_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid    (sample_valid),
    .irq_clear       (irq_clear),
    .cfg_enable      (cfg_enable),
    .cfg_active_high (cfg_active_high),
    .cfg_irq_mode    (cfg_irq_mode),
    .cfg_crit_only   (cfg_crit_only),
    .flag_below      (flag_below),
    .flag_above      (flag_above),
    .flag_crit       (flag_crit),
    .evt_level       (evt_level),
    .evt_oe          (evt_oe)
);

// File: tb/test_thermal_event_gen.sv
module test_thermal_event_gen;
    localparam int TW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic signed [TW-1:0] sample_temp = '0;
    logic signed [TW-1:0] lim_low = '0;
    logic signed [TW-1:0] lim_high = '0;
    logic signed [TW-1:0] lim_crit = '0;
    logic cfg_enable = 1'b0, cfg_active_high = 1'b0, cfg_irq_mode = 1'b0, cfg_crit_only = 1'b0;
    logic irq_clear = 1'b0;
    logic evt_level, evt_oe, flag_below, flag_above, flag_crit;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model
    logic m_below = 0, m_above = 0, m_crit = 0, m_irq = 0, m_armed = 1;

    always #4 clk = ~clk;

    thermal_event_gen #(.TW(TW)) i_thermal_event_gen (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_temp(sample_temp),
        .lim_low(lim_low), .lim_high(lim_high), .lim_crit(lim_crit),
        .cfg_enable(cfg_enable), .cfg_active_high(cfg_active_high),
        .cfg_irq_mode(cfg_irq_mode), .cfg_crit_only(cfg_crit_only), .irq_clear(irq_clear),
        .evt_level(evt_level), .evt_oe(evt_oe),
        .flag_below(flag_below), .flag_above(flag_above), .flag_crit(flag_crit)
    );

    function automatic logic exp_level(input logic en, input logic ah, input logic co,
                                       input logic im, input logic b, input logic a,
                                       input logic c, input logic q);
        logic act;
        if (co)       act = c;
        else if (im)  act = q || c;
        else          act = b || a || c;
        if (!en) return 1'b1;
        return act ? ah : !ah;
    endfunction

    task automatic model_edge();
        logic nb, na, nc, outside;
        nb = m_below; na = m_above; nc = m_crit;
        if (sample_valid) begin
            nb = sample_temp < lim_low;
            na = sample_temp > lim_high;
            nc = sample_temp > lim_crit;
        end
        outside = (sample_temp < lim_low) || (sample_temp > lim_high) || (sample_temp > lim_crit);
        if (cfg_crit_only || !cfg_irq_mode) begin
            m_irq = 1'b0;
            m_armed = 1'b1;
        end else begin
            if (sample_valid && outside && m_armed) m_irq = 1'b1;
            else if (irq_clear) m_irq = 1'b0;
            if (sample_valid) m_armed = !outside;
        end
        m_below = nb; m_above = na; m_crit = nc;
    endtask

    task automatic check_all(input string tag, input logic lvl);
        logic [4:0] act, exp;
        act = {flag_below, flag_above, flag_crit, evt_level, evt_oe};
        exp = {m_below, m_above, m_crit, lvl, !lvl};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {below,above,crit,level,oe} actual %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // drive at negedge, let one edge pass, check at the following negedge
    task automatic step(input logic v, input int t, input logic clr, input string tag);
        logic lvl;
        sample_valid = v;
        sample_temp  = TW'(t);
        irq_clear    = clr;
        @(posedge clk);
        lvl = exp_level(cfg_enable, cfg_active_high, cfg_crit_only, cfg_irq_mode,
                        (v ? (TW'(t) < lim_low) : m_below) == 1'b1 ? 1'b1 : 1'b0, 1'b0, 1'b0, 1'b0);
        model_edge();
        lvl = exp_level(cfg_enable, cfg_active_high, cfg_crit_only, cfg_irq_mode,
                        m_below, m_above, m_crit, m_irq);
        @(negedge clk);
        check_all(tag, lvl);
        sample_valid = 1'b0;
        irq_clear    = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        lim_low  = -11'sd8;
        lim_high = 11'sd340;
        lim_crit = 11'sd380;
        repeat (3) @(negedge clk);
        check_all("R3 reset", 1'b1);
        rst_n = 1'b1;
        cfg_enable = 1'b1;
        @(negedge clk);

        // comparator, active low
        step(1, 100, 0, "R1 inside window");
        step(1, -8, 0, "R1 equal lower not below");
        step(1, -9, 0, "R1 R5 below lower");
        step(0, 500, 0, "R2 hold without strobe");
        step(1, -200, 0, "R1 negative signed");
        step(1, 340, 0, "R1 equal upper not above");
        step(1, 341, 0, "R1 R5 above upper");
        step(1, 381, 0, "R1 critical");
        cfg_active_high = 1'b1;
        step(0, 0, 0, "R4 active high asserted");
        step(1, 50, 0, "R4 R5 released");

        // interrupt mode
        cfg_irq_mode = 1'b1;
        step(1, 100, 0, "R6 inside no event");
        step(1, 341, 0, "R6 latch event");
        step(1, 100, 0, "R6 stays latched");
        step(0, 0, 1, "R6 clear releases");
        step(1, 345, 0, "R6 new event after rearm");
        step(0, 0, 1, "R7 clear");
        step(1, 350, 0, "R7 disarmed no event");
        step(1, -50, 0, "R7 still disarmed");
        step(1, 100, 0, "R7 rearmed no event");
        step(1, 350, 0, "R7 event after rearm");
        step(1, 100, 0, "R11 rearm while pending");
        step(1, 341, 1, "R11 event wins over clear");
        step(0, 0, 1, "R11 clear");
        step(1, 100, 0, "R8 rearm");
        step(1, 400, 0, "R8 critical latches");
        step(0, 0, 1, "R8 clear ignored while critical");
        step(1, 200, 0, "R8 released below critical");

        // critical only
        cfg_crit_only = 1'b1;
        step(1, 341, 0, "R9 above not asserted");
        step(1, -100, 0, "R9 below not asserted");
        step(1, 390, 0, "R9 critical asserted");
        cfg_irq_mode = 1'b0;
        step(1, 380, 0, "R9 equal critical released");
        cfg_crit_only = 1'b0;

        // disabled
        cfg_enable = 1'b0;
        step(1, -100, 0, "R10 released while below");
        step(1, 400, 0, "R10 flags still update");
        cfg_enable = 1'b1;
        step(0, 0, 0, "R10 reenabled asserts");

        // random mix
        void'($urandom(32'd20240611));
        for (int blk = 0; blk < 40; blk++) begin
            lim_low  = TW'($signed($urandom_range(0, 200)) - 100);
            lim_high = TW'($signed($urandom_range(150, 300)));
            lim_crit = TW'($signed($urandom_range(250, 400)));
            cfg_enable      = ($urandom_range(0, 7) != 0);
            cfg_active_high = $urandom_range(0, 1);
            cfg_irq_mode    = ($urandom_range(0, 2) != 0);
            cfg_crit_only   = ($urandom_range(0, 4) == 0);
            for (int k = 0; k < 100; k++) begin
                int base, t;
                case ($urandom_range(0, 3))
                    0: base = lim_low;
                    1: base = lim_high;
                    2: base = lim_crit;
                    default: base = 100;
                endcase
                t = base + $signed($urandom_range(0, 6)) - 3;
                step($urandom_range(0, 2) != 0, t, $urandom_range(0, 3) == 0,
                     "R1 R5 R6 R7 R8 R11 random");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule